// File: doc/BRIEF.md
# DMA Interrupt Collector with Strobe-Controlled Mask

This block gathers the interrupt request lines of a DMA engine and turns them into a single interrupt toward a host processor. Each request line is watched for a rising edge. An edge on a line whose source is enabled latches a pending flag. A combined interrupt output is high while any pending flag belongs to an enabled source.

Software reaches the block through a small register window on a single-cycle bus. The enable mask cannot be written directly. One write-only strobe register sets mask bits and another clears them. A read-only view register shows the mask. A pending-status register shows the latched flags, and writing a one to a flag clears it. Source 0 reports transfer completion and source 1 reports a transfer fault.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask, every pending flag and the edge history. After reset the interrupt output is 0 and every register reads 0.
- R2: Registers are selected by word address: 0x8 clears mask bits, 0x9 sets mask bits, 0xA shows the mask, and 0xB shows and acknowledges pending flags. A read (sel=1, we=0) returns its data on the read port in the cycle after the request. The read port is 0 in cycles that follow no read, and for unmapped addresses. Bits above the source count read 0.
- R3: Writing to 0x9 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 are unchanged.
- R4: Writing to 0x8 clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 are unchanged.
- R5: Reads of 0x8 and 0x9 return 0. Writes to 0xA do not change the mask.
- R6: A rising edge on request line i (bit 0 completion, bit 1 fault) sets pending bit i while mask bit i is 1.
- R7: A request line held high sets its pending bit only once. After that bit is acknowledged it stays clear until the line falls and rises again.
- R8: An edge on a masked source is discarded. Enabling the source afterwards does not make it pending.
- R9: Writing 1 to bit i of 0xB clears pending bit i. Writing 0 leaves the bit unchanged.
- R10: When a captured edge and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R11: The interrupt output equals the OR over sources of (pending AND mask), aligned with the register state. Clearing a mask bit drops the output but keeps the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Interrupt request lines, rising-edge sensitive |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach from the ports is a fresh rising edge that lands in the same clock as a software acknowledge of the same bit. The bench reaches it by timing the status write so that its strobe cycle is exactly the first cycle a request line is high. A second hard case is a request line that stays high across an acknowledge, which shows whether the edge history is kept. The bench holds a line high for several cycles before and after clearing it. A long pseudo-random run then mixes request toggles with every register access. A behavioural model checks the read port and the interrupt output on every clock.

// File: rtl/dma_irq_ctrl_pkg.sv
package dma_irq_ctrl_pkg;
  // Word addresses of the register window
  localparam int unsigned WADDR_MASK_CLR  = 8;
  localparam int unsigned WADDR_MASK_SET  = 9;
  localparam int unsigned WADDR_MASK_VIEW = 10;
  localparam int unsigned WADDR_PENDING   = 11;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MCLR,
    ACC_MSET,
    ACC_MVIEW,
    ACC_PEND
  } acc_kind_e;
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] hist_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) hist_q[g] <= 1'b0;
      else     hist_q[g] <= src_i[g];
    end
    assign rise_o[g] = src_i[g] & ~hist_q[g];
  end

  // R7: a line that was high last cycle cannot report an edge now
  a_r7_no_level_retrigger: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_o & $past(src_i)) == '0));
endmodule

// File: rtl/irq_bus_if.sv
module irq_bus_if
  import dma_irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic              set_en_o,
  output logic              clr_en_o,
  output logic [N_SRC-1:0]  bits_o,
  output logic [N_SRC-1:0]  ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  acc_kind_e        kind;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata_hi;

  always_comb begin
    kind = ACC_NONE;
    if (sel_i) begin
      if      (addr_i == ADDR_W'(WADDR_MASK_CLR))  kind = ACC_MCLR;
      else if (addr_i == ADDR_W'(WADDR_MASK_SET))  kind = ACC_MSET;
      else if (addr_i == ADDR_W'(WADDR_MASK_VIEW)) kind = ACC_MVIEW;
      else if (addr_i == ADDR_W'(WADDR_PENDING))   kind = ACC_PEND;
    end
  end

  assign bits_o   = wdata_i[N_SRC-1:0];
  assign set_en_o = we_i && (kind == ACC_MSET);
  assign clr_en_o = we_i && (kind == ACC_MCLR);
  assign ack_o    = (we_i && (kind == ACC_PEND)) ? wdata_i[N_SRC-1:0] : '0;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_SRC];

  always_comb begin
    rd_mux = '0;
    case (kind)
      ACC_MVIEW: rd_mux = DATA_W'(mask_i);
      ACC_PEND:  rd_mux = DATA_W'(pend_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata_q <= '0;
    else if (sel_i && !we_i) rdata_q <= rd_mux;
    else                    rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  // R2: the read port is idle after any cycle without a read
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && !we_i) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] mask_nxt_o
);
  logic [N_SRC-1:0] mask_q;

  always_comb begin
    mask_nxt_o = mask_q;
    if (clr_en_i)      mask_nxt_o = mask_q & ~bits_i;
    else if (set_en_i) mask_nxt_o = mask_q | bits_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt_o;
  end
  assign mask_o = mask_q;

  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));
  a_r4_clear_lands: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((mask_o & $past(bits_i)) == '0));
  a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (!set_en_i && !clr_en_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] pend_nxt_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] capture;

  assign capture = rise_i & mask_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    // capture first so a same-cycle acknowledge cannot lose the event
    assign pend_nxt_o[g] = capture[g] | (pend_q[g] & ~ack_i[g]);
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= pend_nxt_o[g];
    end
  end
  assign pend_o = pend_q;

  a_r10_capture_wins: assert property (@(posedge clk) disable iff (rst)
    (capture != '0) |=> ((pend_o & $past(capture)) == $past(capture)));
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i != '0) |=> ((pend_o & $past(ack_i & ~capture)) == '0));
  a_r8_set_only_on_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(capture)) == '0));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] rise_w, mask_w, mask_nxt_w, pend_w, pend_nxt_w, bits_w, ack_w;
  logic             set_en_w, clr_en_w, irq_q;

  irq_src_edge #(.N_SRC(N_SRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(req_i), .rise_o(rise_w));

  irq_bus_if #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .sel_i(bus_sel_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .mask_i(mask_w),
    .pend_i(pend_w), .set_en_o(set_en_w), .clr_en_o(clr_en_w),
    .bits_o(bits_w), .ack_o(ack_w), .rdata_o(bus_rdata_o));

  irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .set_en_i(set_en_w), .clr_en_i(clr_en_w),
    .bits_i(bits_w), .mask_o(mask_w), .mask_nxt_o(mask_nxt_w));

  irq_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .rise_i(rise_w), .mask_i(mask_w), .ack_i(ack_w),
    .pend_o(pend_w), .pend_nxt_o(pend_nxt_w));

  // register the combined output from next-state values so it lines up with state
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_nxt_w & mask_nxt_w);
  end
  assign irq_o = irq_q;

  a_r11_irq_tracks_state: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(pend_w & mask_w));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (mask_w == '0 && pend_w == '0 && !irq_o && bus_rdata_o == '0));
endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  localparam int N = 2;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int errors = 0, checks = 0;
  bit done = 0;

  dma_irq_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req_i(req), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq));

  always #4 clk = ~clk;

  // behavioural reference, updated on each rising edge
  bit [N-1:0] m_mask, m_pend, m_hist;
  bit [DW-1:0] m_rd;
  bit m_irq;
  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_pend = '0; m_hist = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      bit [N-1:0] nm, np;
      m_rd = '0;
      if (bus_sel && !bus_we) begin
        if (bus_addr == 4'hA) m_rd = DW'(m_mask);
        if (bus_addr == 4'hB) m_rd = DW'(m_pend);
      end
      for (int i = 0; i < N; i++) begin
        bit rise, ack;
        rise = req[i] && !m_hist[i];
        ack  = bus_sel && bus_we && bus_addr == 4'hB && bus_wdata[i];
        if (rise && m_mask[i]) np[i] = 1'b1;
        else if (ack)          np[i] = 1'b0;
        else                   np[i] = m_pend[i];
        nm[i] = m_mask[i];
        if (bus_sel && bus_we && bus_addr == 4'h8 && bus_wdata[i]) nm[i] = 1'b0;
        if (bus_sel && bus_we && bus_addr == 4'h9 && bus_wdata[i]) nm[i] = 1'b1;
      end
      m_hist = req;
      m_pend = np;
      m_mask = nm;
      m_irq  = |(m_pend & m_mask);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R2 read port: actual=%0h expected=%0h at %0t", bus_rdata, m_rd, $time);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R11 irq: actual=%0b expected=%0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    logic [15:0] lfsr = 16'hACE1;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", DW'(irq), 0);
    rd(4'hA, v); check("R1 mask after reset", v, 0);
    rd(4'hB, v); check("R1 pending after reset", v, 0);
    rd(4'h3, v); check("R2 unmapped read", v, 0);

    // R8 edge while masked is dropped
    req = 2'b01; idle(1); req = 2'b00; idle(1);
    rd(4'hB, v); check("R8 masked edge", v, 0);
    wr(4'h9, 32'hFFFF_FFFD);
    rd(4'hA, v); check("R3 set only one bits", v, 32'h1);
    rd(4'hB, v); check("R8 late enable no capture", v, 0);

    // R5 write-only reads and read-only mask
    wr(4'hA, 32'h3);
    rd(4'hA, v); check("R5 mask write ignored", v, 32'h1);
    rd(4'h8, v); check("R5 clear strobe reads zero", v, 0);
    rd(4'h9, v); check("R5 set strobe reads zero", v, 0);

    // R6 completion edge, held high
    req = 2'b01; idle(1);
    check("R6 irq after edge", DW'(irq), 1);
    rd(4'hB, v); check("R6 pending bit0", v, 32'h1);
    wr(4'hB, 32'h0);
    rd(4'hB, v); check("R9 zero write keeps", v, 32'h1);
    wr(4'hB, 32'h1);
    idle(3);
    rd(4'hB, v); check("R7 held level no retrigger", v, 0);
    check("R9 irq after ack", DW'(irq), 0);

    // R6 fault source
    req = 2'b00; idle(1);
    wr(4'h9, 32'h2);
    rd(4'hA, v); check("R3 mask both", v, 32'h3);
    req = 2'b10; idle(1); req = 2'b00; idle(1);
    rd(4'hB, v); check("R6 pending bit1", v, 32'h2);
    check("R11 irq on fault", DW'(irq), 1);

    // R4 / R11 disable keeps pending, drops irq
    wr(4'h8, 32'hFFFF_FFFE);
    check("R11 irq dropped by mask", DW'(irq), 0);
    rd(4'hA, v); check("R4 mask cleared bit1", v, 32'h1);
    rd(4'hB, v); check("R11 pending kept", v, 32'h2);

    // R10 edge and acknowledge in the same cycle
    req = 2'b01;
    wr(4'hB, 32'h3);
    rd(4'hB, v); check("R10 capture beats ack", v, 32'h1);
    check("R10 irq", DW'(irq), 1);

    // R1 reset mid-run
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(1);
    check("R1 irq after second reset", DW'(irq), 0);
    rd(4'hA, v); check("R1 mask after second reset", v, 0);
    rd(4'hB, v); check("R1 pending after second reset", v, 0);

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req = lfsr[1:0];
      bus_sel = lfsr[2];
      bus_we = lfsr[3];
      bus_addr = (lfsr[8] & lfsr[9]) ? 4'h2 : 4'h8 + {2'b00, lfsr[5:4]};
      bus_wdata = {lfsr[15:10], 24'h0, lfsr[7:6]};
      @(negedge clk);
    end
    bus_sel = 1'b0; bus_we = 1'b0;
    idle(2);
    finish_run();
  end
endmodule